// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels may use the system bus next. Each channel has a level-sensitive request input and a transfer counter that software loads through a load strobe. When the arbiter is idle it looks at every channel that is both requesting and enabled, and picks the lowest-numbered one. It then asks the CPU for the bus. Once the CPU acknowledges, it starts exactly one transfer unit on the transfer engine and waits for the engine to report completion.

After every unit the arbiter drops its bus request and waits until the CPU has taken the bus back. Only then does it look at the requests again. The CPU therefore always gets at least one clock between two DMA units. A channel whose request is still high after its unit is served again, one unit per grant, until its counter reaches zero. At that point the channel emits a one-cycle terminal-count pulse and disables itself.

The states are `ST_IDLE`, `ST_GRANT`, `ST_BUSY` and `ST_RELEASE`. The transitions are:
- `ST_IDLE` → `ST_GRANT` when a channel is pending.
- `ST_GRANT` → `ST_BUSY` on CPU acknowledge, which also raises the start pulse.
- `ST_BUSY` → `ST_RELEASE` on engine done.
- `ST_RELEASE` → `ST_IDLE` once the acknowledge is low.

A synchronous active-high reset returns the block to `ST_IDLE`.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the bus request, start pulse and terminal-count pulses are low, and every channel enable is low.
- R2: A load strobe on channel i takes the count from bits [16*i+15:16*i] of the count bus. The channel enable becomes 1 if that count is nonzero and 0 if it is zero.
- R3: Each start pulse names, on the channel-index output, the lowest-numbered channel that was both requesting and enabled when the arbiter was idle. Channel 0 has the highest priority.
- R4: The start pulse lasts one cycle and occurs only while the bus request and the CPU acknowledge are both high. The cycle after the engine done is accepted, the bus request is low.
- R5: Between any two start pulses there is at least one cycle in which the bus request and the CPU acknowledge are both low.
- R6: A channel that keeps requesting receives exactly as many units as its loaded count.
- R7: The cycle after the done of a channel's final unit, that channel's terminal-count pulse is high for one cycle and its enable drops to 0. At most one terminal-count pulse is high at any time.
- R8: A request from the channel in its transfer cycle that has gone low again before the arbiter is idle produces no further unit.
- R9: A higher-priority channel that starts requesting while a lower one is being served wins the very next grant.
- R10: Once raised, the bus request stays high until the CPU acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | 4 | Level-sensitive request per channel |
| ch_load | input | 4 | Per-channel count load strobe |
| ch_count_in | input | 64 | Packed 16-bit count values, channel i in bits [16*i+15:16*i] |
| bus_ack | input | 1 | CPU has handed the bus to DMA |
| xfer_done | input | 1 | Transfer engine finished the current unit |
| dma_bus_req | output | 1 | Bus request towards the CPU |
| xfer_start | output | 1 | One-cycle start of a transfer unit |
| xfer_ch | output | 2 | Channel index of the unit being transferred |
| tc_pulse | output | 4 | One-cycle terminal-count pulse per channel |
| ch_en | output | 4 | Channel enable per channel |

## Verification
The hardest case to reach from the ports is a change in requests while a unit is in flight. One kind is a higher-priority channel appearing during a lower channel's transfer. The other is the serving channel briefly re-asserting and then dropping its own request before the arbiter returns to idle. The stimulus times these changes to the cycle after an observed start pulse. Random request flips are injected at exactly that point, between directed sequences that force each order. The bench's own model then predicts the next winner from the request levels that are present when the arbiter next becomes idle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_BUSY    = 2'd2,
        ST_RELEASE = 2'd3
    } arb_state_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          valid
);
    // lowest index wins: scan downwards so the last hit is the smallest
    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IW'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_chan_counter.sv
module dma_chan_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          en,
    output logic          tc
);
    logic [CW-1:0] cnt_q;
    logic          last_unit;

    assign last_unit = (cnt_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en    <= 1'b0;
            tc    <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (load) begin
                cnt_q <= load_val;
                en    <= (load_val != '0);
            end else if (dec && en) begin
                cnt_q <= cnt_q - CW'(1);
                if (last_unit) begin
                    en <= 1'b0;
                    tc <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ch_req,
    input  logic [NCH-1:0]    ch_load,
    input  logic [NCH*CW-1:0] ch_count_in,
    input  logic              bus_ack,
    input  logic              xfer_done,
    output logic              dma_bus_req,
    output logic              xfer_start,
    output logic [CHW-1:0]    xfer_ch,
    output logic [NCH-1:0]    tc_pulse,
    output logic [NCH-1:0]    ch_en
);
    arb_state_e     state_q, state_d;
    logic [CHW-1:0] act_q;
    logic [NCH-1:0] pending;
    logic [CHW-1:0] pick_idx;
    logic           pick_valid;
    logic           unit_done;

    assign pending   = ch_req & ch_en;
    assign unit_done = (state_q == ST_BUSY) && xfer_done;

    dma_prio_pick #(.N(NCH), .IW(CHW)) u_pick (
        .req   (pending),
        .idx   (pick_idx),
        .valid (pick_valid)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dma_chan_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (ch_load[g]),
            .load_val (ch_count_in[g*CW +: CW]),
            .dec      (unit_done && (act_q == CHW'(g))),
            .en       (ch_en[g]),
            .tc       (tc_pulse[g])
        );
    end

    // state register and winner latch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && pick_valid) begin
                act_q <= pick_idx;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pick_valid && !bus_ack) state_d = ST_GRANT;
            ST_GRANT:   if (bus_ack)                state_d = ST_BUSY;
            ST_BUSY:    if (xfer_done)              state_d = ST_RELEASE;
            ST_RELEASE: if (!bus_ack)               state_d = ST_IDLE;
            default:                                state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dma_bus_req = 1'b0;
        xfer_start  = 1'b0;
        unique case (state_q)
            ST_GRANT: begin
                dma_bus_req = 1'b1;
                xfer_start  = bus_ack;
            end
            ST_BUSY:  dma_bus_req = 1'b1;
            default: ;
        endcase
    end

    assign xfer_ch = act_q;
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2
) (
    input logic           clk,
    input logic           rst,
    input arb_state_e     state_q,
    input logic           bus_ack,
    input logic           xfer_done,
    input logic           dma_bus_req,
    input logic           xfer_start,
    input logic [CHW-1:0] xfer_ch,
    input logic [NCH-1:0] tc_pulse,
    input logic [NCH-1:0] ch_en
);
    p_start_acked_r4: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> (dma_bus_req && bus_ack));

    p_done_releases_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && xfer_done) |=> !dma_bus_req);

    p_start_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        xfer_start |-> ch_en[xfer_ch]);

    p_cpu_gap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_bus_req) |-> !$past(bus_ack));

    p_tc_single_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tc_pulse));

    p_tc_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        (|tc_pulse) |-> $past(xfer_done));

    p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
        (dma_bus_req && !bus_ack) |=> dma_bus_req);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .bus_ack     (bus_ack),
    .xfer_done   (xfer_done),
    .dma_bus_req (dma_bus_req),
    .xfer_start  (xfer_start),
    .xfer_ch     (xfer_ch),
    .tc_pulse    (tc_pulse),
    .ch_en       (ch_en)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;
    localparam int NCH = 4;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    ch_req = '0;
    logic [NCH-1:0]    ch_load = '0;
    logic [NCH*CW-1:0] ch_count_in = '0;
    logic              bus_ack = 1'b0;
    logic              xfer_done = 1'b0;
    logic              dma_bus_req;
    logic              xfer_start;
    logic [1:0]        xfer_ch;
    logic [NCH-1:0]    tc_pulse;
    logic [NCH-1:0]    ch_en;

    always #5 clk = ~clk;

    dma_req_arbiter #(.NCH(NCH), .CW(CW)) u_dma_req_arbiter (
        .clk(clk), .rst(rst), .ch_req(ch_req), .ch_load(ch_load),
        .ch_count_in(ch_count_in), .bus_ack(bus_ack), .xfer_done(xfer_done),
        .dma_bus_req(dma_bus_req), .xfer_start(xfer_start), .xfer_ch(xfer_ch),
        .tc_pulse(tc_pulse), .ch_en(ch_en)
    );

    int total = 0;
    int bad = 0;

    // bench model
    int          model_cnt [NCH];
    logic [3:0]  model_en = '0;
    int          units [NCH];
    int          start_log [$];
    logic        s_req = 1'b0, s_ack = 1'b0, s_start = 1'b0;
    logic        gap_seen = 1'b1;
    logic        tc_chk = 1'b0;
    int          tc_ch = 0;
    logic        eng_busy = 1'b0;
    int          eng_lat = 0;
    int          cur_ch = 0;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [3:0] v);
        for (int i = 0; i < NCH; i++) if (v[i]) return i;
        return -1;
    endfunction

    // CPU and engine responder, then sampler/monitor
    always @(negedge clk) begin
        if (xfer_done) xfer_done = 1'b0;
        else if (eng_busy) begin
            if (eng_lat == 0) begin xfer_done = 1'b1; eng_busy = 1'b0; end
            else eng_lat--;
        end
        bus_ack = s_req;
        #1;
        if (!rst) begin
            if (tc_chk) begin
                logic last;
                last = (model_cnt[tc_ch] == 1);
                check(tc_pulse == (last ? 4'(1 << tc_ch) : 4'd0), "R7 tc pulse", tc_pulse, last ? (1 << tc_ch) : 0);
                check(!dma_bus_req, "R4 bus released after done", dma_bus_req, 0);
                model_cnt[tc_ch]--;
                if (model_cnt[tc_ch] == 0) model_en[tc_ch] = 1'b0;
                check(ch_en == model_en, "R7 enable after unit", ch_en, model_en);
                tc_chk = 1'b0;
            end
            if (xfer_done) begin tc_chk = 1'b1; tc_ch = cur_ch; end
            if (s_req && !s_ack) check(dma_bus_req, "R10 request held", dma_bus_req, 1);
            if (!dma_bus_req && !bus_ack) gap_seen = 1'b1;
            if (xfer_start) begin
                int exp;
                exp = lowest(ch_req & model_en);
                check(int'(xfer_ch) == exp, "R3 winner", xfer_ch, exp);
                check(gap_seen, "R5 cpu gap before unit", gap_seen, 1);
                check(s_start == 1'b0, "R4 single start cycle", s_start, 0);
                gap_seen = 1'b0;
                cur_ch   = xfer_ch;
                units[xfer_ch]++;
                start_log.push_back(int'(xfer_ch));
                eng_busy = 1'b1;
                eng_lat  = $urandom % 3;
            end
        end
        s_req   = dma_bus_req;
        s_ack   = bus_ack;
        s_start = xfer_start;
    end

    task automatic load(input int ch, input int cnt);
        @(negedge clk);
        ch_load[ch] = 1'b1;
        ch_count_in[ch*CW +: CW] = CW'(cnt);
        model_cnt[ch] = cnt;
        model_en[ch]  = (cnt != 0);
        @(negedge clk);
        ch_load = '0;
        #2;
        check(ch_en == model_en, "R2 enable after load", ch_en, model_en);
    endtask

    task automatic wait_quiet();
        int n = 0;
        while (n < 8) begin
            @(negedge clk);
            #2;
            if ((ch_req & model_en) == 0 && !dma_bus_req && !bus_ack && !tc_chk && !xfer_done) n++;
            else n = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NCH; i++) begin model_cnt[i] = 0; units[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        check(!dma_bus_req && !xfer_start && tc_pulse == 0 && ch_en == 0, "R1 reset state",
              {dma_bus_req, xfer_start, tc_pulse, ch_en}, 0);

        // R2: zero count leaves channel disabled
        load(2, 0);
        // R6: held request served exactly count units
        load(1, 4);
        ch_req = 4'b0010;
        wait_quiet();
        check(units[1] == 4, "R6 unit count", units[1], 4);
        ch_req = '0;

        // R9: higher priority appears during lower transfer
        load(3, 3);
        load(0, 1);
        start_log.delete();
        ch_req = 4'b1000;
        while (start_log.size() == 0) @(negedge clk);
        ch_req = 4'b1001;
        wait_quiet();
        check(start_log.size() >= 2 && start_log[1] == 0, "R9 preempt next grant",
              start_log.size() >= 2 ? start_log[1] : -1, 0);
        ch_req = '0;

        // R8: own re-request pulsed during its transfer is dropped
        load(1, 3);
        units[1] = 0;
        ch_req = 4'b0010;
        while (units[1] == 0) @(negedge clk);
        ch_req = 4'b0000;
        @(negedge clk);
        ch_req = 4'b0010;
        @(negedge clk);
        ch_req = 4'b0000;
        repeat (20) @(negedge clk);
        check(units[1] == 1, "R8 re-request ignored", units[1], 1);
        check(ch_en[1] == 1'b1, "R8 channel still enabled", ch_en[1], 1);

        // random phases
        for (int it = 0; it < 30; it++) begin
            for (int c = 0; c < NCH; c++)
                if ($urandom % 2 == 0) load(c, $urandom % 5);
            ch_req = 4'($urandom % 16);
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (s_start && ($urandom % 3 == 0)) ch_req[$urandom % NCH] ^= 1'b1;
            end
            ch_req = '0;
            wait_quiet();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule